// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block belongs to one UART channel. It watches five interrupt conditions, each with its own enable: a line-status error, a receive time-out, received data at or above the trigger, an empty transmit holding register, and a modem-status change. It ranks them and presents the highest-ranked pending one as a coded status byte for the host to read. An interrupt line follows that byte.

The block also holds the FIFO control state: a FIFO-enable bit and a two-bit receive trigger selection, both written by the host. The receive trigger sets how many buffered bytes raise the data-ready condition.

Line errors, time-outs, modem changes and the receive fill level are levels that the surrounding logic holds until its own service action. The transmit-empty condition arrives as a one-cycle pulse and is latched inside the block. Reading the status byte clears the latched transmit-empty flag only when that source is the one being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the status byte reads 0x01, `irq` is low, `fifo_en` is 0 and `rx_trig` is 00.
- R2: Status bits [3:0] give the winning source. The order runs from line error (0110, highest), through receive level 2, then transmit-empty (0010), down to modem change (0000, lowest). The value 0001 means nothing is pending.
- R3: Within level 2, an enabled receive time-out reports 1100 ahead of data-ready (0100). Data-ready is reported when `rx_level` is greater than or equal to the trigger count.
- R4: `irq` is high exactly when status bit 0 is 0.
- R5: A source whose enable is low takes no part in arbitration, and a lower-ranked enabled source is reported in its place. `en_rx` gates both the time-out and data-ready.
- R6: Status bits [5:4] always read 0. Bits [7:6] read 11 while the FIFOs are enabled and 00 while they are disabled.
- R7: Every FIFO control write loads data bit 0 into `fifo_en`. Data bits [7:6] are loaded into `rx_trig` only when data bit 0 is 1 in the same write; otherwise `rx_trig` keeps its value.
- R8: The trigger codes map to byte counts as follows: 00 = 1, 01 = 4, 10 = 8, 11 = 14. While `fifo_en` is 0 the trigger count is 1, whatever `rx_trig` holds.
- R9: A `thr_set` pulse latches a pending transmit-empty flag. A `status_rd` clears it only while status bits [3:0] read 0010; a read while another source is reported leaves it pending.
- R10: The status byte is registered. It reflects the inputs and the internal state sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| en_line | input | 1 | Enable for the line-status error |
| en_rx | input | 1 | Enable for receive time-out and data-ready |
| en_thr | input | 1 | Enable for transmit-empty |
| en_modem | input | 1 | Enable for modem-status change |
| line_err | input | 1 | Line-status error pending (level) |
| rx_timeout | input | 1 | Receive time-out pending (level) |
| rx_level | input | LVL_W | Bytes currently held in the receive FIFO |
| thr_set | input | 1 | Transmit holding register became empty (pulse) |
| modem_chg | input | 1 | Modem-status change pending (level) |
| status_rd | input | 1 | Host reads the status byte this cycle |
| status | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request, active high |
| fifo_en | output | 1 | FIFO enable state |
| rx_trig | output | 2 | Receive trigger selection |

## Verification
The assertions assume that each level input stays stable for at least one clock after a change. They also assume that `status_rd` and `thr_set` are not asserted in the same cycle when the clear check applies, and that `rx_level` never exceeds the FIFO depth. The stimulus respects all three. It changes inputs only at the falling edge, holds each combination for a full cycle before sampling, and issues status reads only in cycles that carry no transmit-empty pulse. The FIFO fill level stays within 0 to 16.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int LVL_W  = 5,
  parameter int TRIG_A = 1,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  input  logic             en_line,
  input  logic             en_rx,
  input  logic             en_thr,
  input  logic             en_modem,
  input  logic             line_err,
  input  logic             rx_timeout,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             thr_set,
  input  logic             modem_chg,
  input  logic             status_rd,
  output logic [7:0]       status,
  output logic             irq,
  output logic             fifo_en,
  output logic [1:0]       rx_trig
);
  localparam logic [3:0] C_LINE  = 4'b0110;
  localparam logic [3:0] C_TOUT  = 4'b1100;
  localparam logic [3:0] C_READY = 4'b0100;
  localparam logic [3:0] C_THR   = 4'b0010;
  localparam logic [3:0] C_MODEM = 4'b0000;
  localparam logic [3:0] C_NONE  = 4'b0001;

  logic             thr_pend;
  logic [LVL_W-1:0] trig_cnt;
  logic             rx_ready;
  logic [3:0]       code_nxt;
  logic [7:0]       status_q;

  always_comb begin
    unique case (fifo_en ? rx_trig : 2'b00)
      2'b00:   trig_cnt = LVL_W'(TRIG_A);
      2'b01:   trig_cnt = LVL_W'(TRIG_B);
      2'b10:   trig_cnt = LVL_W'(TRIG_C);
      default: trig_cnt = LVL_W'(TRIG_D);
    endcase
  end

  assign rx_ready = rx_level >= trig_cnt;

  always_comb begin
    if (en_line && line_err)        code_nxt = C_LINE;
    else if (en_rx && rx_timeout)   code_nxt = C_TOUT;
    else if (en_rx && rx_ready)     code_nxt = C_READY;
    else if (en_thr && thr_pend)    code_nxt = C_THR;
    else if (en_modem && modem_chg) code_nxt = C_MODEM;
    else                            code_nxt = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      rx_trig <= 2'b00;
    end else if (fcr_wr) begin
      fifo_en <= fcr_wdata[0];
      if (fcr_wdata[0]) rx_trig <= fcr_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      thr_pend <= 1'b0;
    else if (thr_set)                                thr_pend <= 1'b1;
    else if (status_rd && status_q[3:0] == C_THR)    thr_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= {4'b0000, C_NONE};
    else        status_q <= {{2{fifo_en}}, 2'b00, code_nxt};
  end

  assign status = status_q;
  assign irq    = ~status_q[0];

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (en_line && line_err) |=> (status[3:0] == C_LINE)); // R2
  AST_TOUT_OVER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx && rx_timeout && !(en_line && line_err)) |=> (status[3:0] == C_TOUT)); // R3
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_line && !en_rx && !en_thr && !en_modem) |=> (status[0] && !irq)); // R5
  AST_FCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && !fcr_wdata[0]) |=> ($stable(rx_trig) && !fifo_en)); // R7
  AST_FCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_wdata[0]) |=> (fifo_en && rx_trig == $past(fcr_wdata[7:6]))); // R7
  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && status[3:0] == C_THR && !thr_set) |=> !thr_pend); // R9
  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[5:4] == 2'b00 && status[7:6] == {2{$past(fifo_en)}})); // R6
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = 8'h00;
  logic en_line = 1'b0, en_rx = 1'b0, en_thr = 1'b0, en_modem = 1'b0;
  logic line_err = 1'b0, rx_timeout = 1'b0, thr_set = 1'b0, modem_chg = 1'b0;
  logic status_rd = 1'b0;
  logic [4:0] rx_level = 5'd0;
  logic [7:0] status;
  logic irq, fifo_en;
  logic [1:0] rx_trig;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .en_line(en_line), .en_rx(en_rx), .en_thr(en_thr), .en_modem(en_modem),
    .line_err(line_err), .rx_timeout(rx_timeout), .rx_level(rx_level),
    .thr_set(thr_set), .modem_chg(modem_chg), .status_rd(status_rd),
    .status(status), .irq(irq), .fifo_en(fifo_en), .rx_trig(rx_trig));

  // [15:12] enables {line,rx,thr,modem}, [11] line_err, [10] rx_timeout,
  // [9] modem_chg, [8:4] rx_level, [3:0] expected status[3:0]; FIFOs off
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'hF001, 16'hF806, 16'hFE56, 16'hF40C, 16'hF014, 16'hF43C,
    16'hF200, 16'hF224, 16'h7A00, 16'hB640, 16'hE201, 16'h0F01};

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fcr_write(logic [7:0] d);
    fcr_wr = 1'b1; fcr_wdata = d;
    step();
    fcr_wr = 1'b0;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 status", status, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 fifo_en/trig", {5'd0, fifo_en, rx_trig}, 8'h00);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      {en_line, en_rx, en_thr, en_modem} = VEC[i][15:12];
      line_err = VEC[i][11]; rx_timeout = VEC[i][10]; modem_chg = VEC[i][9];
      rx_level = VEC[i][8:4];
      step();
      check($sformatf("R2/R3/R5 vec %0d", i), status, {4'b0000, VEC[i][3:0]});
      check($sformatf("R4 vec %0d", i), {7'd0, irq}, {7'd0, ~VEC[i][0]});
    end

    {en_line, en_rx, en_thr, en_modem} = 4'hF;
    line_err = 0; rx_timeout = 0; modem_chg = 0; rx_level = 0;
    step();

    // R7 R8 R6: enable FIFOs with trigger 14
    fcr_write(8'hC1);
    check("R7 load", {5'd0, fifo_en, rx_trig}, 8'h07);
    check("R6 fifo on idle", status, 8'hC1);
    rx_level = 5'd13; step();
    check("R8 below 14", status, 8'hC1);
    rx_level = 5'd14; step();
    check("R8 at 14", status, 8'hC4);

    // R7: write with bit0 clear keeps the trigger, disables the FIFOs
    rx_level = 5'd1;
    fcr_write(8'h40);
    check("R7 ignored trigger", {5'd0, fifo_en, rx_trig}, 8'h03);
    check("R8 fifo off trig 1 / R6", status, 8'h04);

    fcr_write(8'h81);
    rx_level = 5'd7; step();
    check("R8 below 8", status, 8'hC1);
    rx_level = 5'd8; step();
    check("R8 at 8", status, 8'hC4);
    fcr_write(8'h41);
    rx_level = 5'd3; step();
    check("R8 below 4", status, 8'hC1);
    rx_level = 5'd4; step();
    check("R8 at 4", status, 8'hC4);
    rx_level = 5'd0;
    fcr_write(8'h00);
    check("R6 fifo off", status, 8'h01);

    // R9: transmit-empty latch and read clear
    thr_set = 1'b1; step(); thr_set = 1'b0;
    step();
    check("R9 thr reported", status, 8'h02);
    check("R4 irq thr", {7'd0, irq}, 8'h01);
    status_rd = 1'b1; step(); status_rd = 1'b0;
    check("R10 one cycle later", status, 8'h02);
    step();
    check("R9 cleared by read", status, 8'h01);

    // R9: read while line error reported keeps thr pending
    thr_set = 1'b1; line_err = 1'b1; step(); thr_set = 1'b0;
    step();
    check("R2 line over thr", status, 8'h06);
    status_rd = 1'b1; step(); status_rd = 1'b0;
    line_err = 1'b0; step(); step();
    check("R9 thr survives other read", status, 8'h02);

    // R5: masked thr stays pending
    en_thr = 1'b0; step();
    check("R5 thr masked", status, 8'h01);
    en_thr = 1'b1; step();
    check("R5 thr unmasked", status, 8'h02);
    status_rd = 1'b1; step(); status_rd = 1'b0; step();
    check("R9 final clear", status, 8'h01);

    // R1: reset in mid-operation
    fcr_write(8'hC1);
    line_err = 1'b1;
    rst_n = 1'b0; step();
    check("R1 reset again", {status[7:0]}, 8'h01);
    check("R1 fcr reset", {5'd0, fifo_en, rx_trig}, 8'h00);
    rst_n = 1'b1; line_err = 1'b0;
    step();
    finish_run();
  end
endmodule